// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration front end of a multi-function peripheral controller. A host reaches it through two byte-wide I/O locations on a simple bus with a 16-bit address, write and read strobes and 8-bit data. The lower of the two locations is the index port and the one above it is the data port. A strap input picks which pair the block answers to. The registers stay locked until a two-byte key is written to the index port. A single exit byte locks them again.

While unlocked, the host writes a register number to the index port. It then reads or writes that register through the data port. A few registers are shared by the whole block: the device selector and two read-only identification bytes. The enable and base-address registers come in one copy per logical device, and the device selector picks which copy the data port reaches. Each device's enable bit and 16-bit base address drive downstream logic continuously.

Top module: `idxcfg_top`

## Requirements
- R1: With `strap_alt` = 0 the index port is at address 0x002E and the data port is at 0x002F. With `strap_alt` = 1 they are at 0x004E and 0x004F. Accesses to any other address have no effect on state, and reading them gives `bus_rdata` = 0x00.
- R2: The block unlocks only after two writes of 0x87 to the index port with no other index-port write between them. While locked, any other byte written to the index port restarts the key count. Data-port accesses do not disturb the key count.
- R3: Writing 0xAA to the index port while unlocked locks the block again and leaves the stored index unchanged.
- R4: While locked, data-port writes are ignored. Data-port reads and index-port reads both return 0xFF.
- R5: While unlocked, an index-port write (other than 0xAA) stores a register number. An index-port read returns that number, and data-port accesses act on the register it names.
- R6: Register 0x07 holds the selected logical device number and reads back its value. A write of 8 or more to it is ignored.
- R7: Register 0x20 returns the `CHIP_ID` parameter and register 0x27 returns the `REV_ID` parameter. Writes to either register have no effect.
- R8: Register 0x30 of the selected device holds that device's enable in bit 0. The enable appears on `dev_en[d]`. The other bits read as 0, and each device keeps its own copy.
- R9: Register 0x60 of the selected device holds bits 15:8 of its base address and register 0x61 holds bits 7:0. The address appears on `dev_base[16*d+15:16*d]`.
- R10: Any other register number reads 0x00, and a data-port write to it changes nothing.
- R11: A synchronous reset locks the block and clears the key count, the index, the device selector, every enable and every base address.
- R12: `bus_rdata` carries the result of a port read in the cycle after the read strobe was sampled. It is 0x00 after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt | input | 1 | Port pair select: 0 = 0x2E/0x2F, 1 = 0x4E/0x4F |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_en | output | NDEV | Enable bit of each logical device |
| dev_base | output | 16*NDEV | Base address of each logical device, device d in bits 16d+15:16d |

## Verification
On every cycle the assertions check four things. Locked data-port writes leave the exported enables and bases frozen, and locked data reads give 0xFF. Unlocking follows an index write of 0x87, and the exit byte always locks. A device number that is out of range leaves the selector alone, and identification reads return the parameters. The full key sequence with interruptions is shown only by the bench's scenarios, which compare against a reference model on every clock. The same holds for the banking of registers 0x30/0x60/0x61 across devices, the switch of port pair by the strap, and the values after a reset in mid-run.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;

  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] REG_LDN = 8'h07;
  localparam logic [7:0] REG_ID  = 8'h20;
  localparam logic [7:0] REG_REV = 8'h27;
  localparam logic [7:0] REG_EN  = 8'h30;
  localparam logic [7:0] REG_BHI = 8'h60;
  localparam logic [7:0] REG_BLO = 8'h61;

  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_t;

endpackage

// File: rtl/idxcfg_unlock.sv
module idxcfg_unlock
  import idxcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);

  lock_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_LOCKED;
    end else if (idx_wr) begin
      unique case (state_q)
        LK_LOCKED: state_q <= (wdata == KEY_ENTER) ? LK_HALF : LK_LOCKED;
        LK_HALF:   state_q <= (wdata == KEY_ENTER) ? LK_OPEN : LK_LOCKED;
        LK_OPEN:   state_q <= (wdata == KEY_EXIT)  ? LK_LOCKED : LK_OPEN;
        default:   state_q <= LK_LOCKED;
      endcase
    end
  end

  assign cfg_open = (state_q == LK_OPEN);

endmodule

// File: rtl/idxcfg_bank.sv
module idxcfg_bank
  import idxcfg_pkg::*;
#(
  parameter int BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        reg_num,
  input  logic [7:0]        wdata,
  output logic              en_q,
  output logic [BASE_W-1:0] base_q
);

  localparam int HI_W = BASE_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      base_q <= '0;
    end else if (wr_en) begin
      case (reg_num)
        REG_EN:  en_q <= wdata[0];
        REG_BHI: base_q[BASE_W-1:8] <= wdata[HI_W-1:0];
        REG_BLO: base_q[7:0] <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/idxcfg_top.sv
module idxcfg_top
  import idxcfg_pkg::*;
#(
  parameter int          NDEV    = 8,
  parameter logic [7:0]  CHIP_ID = 8'hA5,
  parameter logic [7:0]  REV_ID  = 8'h03,
  parameter logic [15:0] PAIR_LO = 16'h002E,
  parameter logic [15:0] PAIR_HI = 16'h004E
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strap_alt,
  input  logic [15:0]        bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [NDEV-1:0]    dev_en,
  output logic [NDEV*16-1:0] dev_base
);

  localparam int LDN_W = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic [15:0] idx_addr;
  logic        idx_hit, dat_hit;
  logic        idx_wr, idx_rd, dat_wr, dat_rd;
  logic        cfg_open;
  logic [7:0]  idx_q;
  logic [LDN_W-1:0] ldn_q;
  logic        en_w   [NDEV];
  logic [15:0] base_w [NDEV];
  logic [7:0]  reg_val;
  logic [7:0]  rd_next;

  assign idx_addr = strap_alt ? PAIR_HI : PAIR_LO;
  assign idx_hit  = (bus_addr == idx_addr);
  assign dat_hit  = (bus_addr == idx_addr + 16'd1);
  assign idx_wr   = bus_wr & idx_hit;
  assign idx_rd   = bus_rd & idx_hit;
  assign dat_wr   = bus_wr & dat_hit;
  assign dat_rd   = bus_rd & dat_hit;

  idxcfg_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .cfg_open (cfg_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_wr && cfg_open && bus_wdata != KEY_EXIT)
        idx_q <= bus_wdata;
      if (dat_wr && cfg_open && idx_q == REG_LDN && int'(bus_wdata) < NDEV)
        ldn_q <= bus_wdata[LDN_W-1:0];
    end
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    logic sel_wr;
    assign sel_wr = dat_wr & cfg_open & (int'(ldn_q) == g);

    idxcfg_bank #(.BASE_W(16)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (sel_wr),
      .reg_num (idx_q),
      .wdata   (bus_wdata),
      .en_q    (en_w[g]),
      .base_q  (base_w[g])
    );

    assign dev_en[g]             = en_w[g];
    assign dev_base[16*g +: 16]  = base_w[g];
  end

  always_comb begin
    case (idx_q)
      REG_LDN: reg_val = 8'(ldn_q);
      REG_ID:  reg_val = CHIP_ID;
      REG_REV: reg_val = REV_ID;
      REG_EN:  reg_val = {7'd0, en_w[ldn_q]};
      REG_BHI: reg_val = base_w[ldn_q][15:8];
      REG_BLO: reg_val = base_w[ldn_q][7:0];
      default: reg_val = 8'h00;
    endcase
  end

  always_comb begin
    rd_next = 8'h00;
    if (idx_rd)      rd_next = cfg_open ? idx_q   : LOCKED_READ;
    else if (dat_rd) rd_next = cfg_open ? reg_val : LOCKED_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/idxcfg_chk.sv
module idxcfg_chk
  import idxcfg_pkg::*;
#(
  parameter int         NDEV    = 8,
  parameter logic [7:0] CHIP_ID = 8'hA5,
  parameter logic [7:0] REV_ID  = 8'h03,
  parameter int         LDN_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_open,
  input logic               idx_wr,
  input logic               dat_wr,
  input logic               dat_rd,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic [7:0]         idx_q,
  input logic [LDN_W-1:0]   ldn_q,
  input logic [NDEV-1:0]    dev_en,
  input logic [NDEV*16-1:0] dev_base
);

  assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && dat_wr) |=> ($stable(dev_en) && $stable(dev_base)));

  assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && dat_rd) |=> (bus_rdata == 8'hFF));

  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(idx_wr && bus_wdata == KEY_ENTER));

  assert_exit_locks_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && idx_wr && bus_wdata == KEY_EXIT) |=> !cfg_open);

  assert_ldn_range_R6: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && idx_q == REG_LDN && int'(bus_wdata) >= NDEV) |=> $stable(ldn_q));

  assert_chip_id_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && dat_rd && idx_q == REG_ID) |=> (bus_rdata == CHIP_ID));

  assert_rev_id_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && dat_rd && idx_q == REG_REV) |=> (bus_rdata == REV_ID));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (dev_en == '0 && dev_base == '0 && !cfg_open && bus_rdata == 8'h00));

endmodule

bind idxcfg_top idxcfg_chk #(
  .NDEV(NDEV), .CHIP_ID(CHIP_ID), .REV_ID(REV_ID), .LDN_W(LDN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_open  (cfg_open),
  .idx_wr    (idx_wr),
  .dat_wr    (dat_wr),
  .dat_rd    (dat_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .idx_q     (idx_q),
  .ldn_q     (ldn_q),
  .dev_en    (dev_en),
  .dev_base  (dev_base)
);

// File: tb/tb_idxcfg_top.sv
module tb_idxcfg_top;

  localparam int CLK_P = 10;
  localparam int NDEV  = 8;
  localparam logic [7:0] CHIP_ID = 8'hA5;
  localparam logic [7:0] REV_ID  = 8'h03;

  logic               clk = 1'b0;
  logic               rst = 1'b0;
  logic               strap_alt = 1'b0;
  logic [15:0]        bus_addr = '0;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [7:0]         bus_wdata = '0;
  logic [7:0]         bus_rdata;
  logic [NDEV-1:0]    dev_en;
  logic [NDEV*16-1:0] dev_base;

  idxcfg_top #(.NDEV(NDEV), .CHIP_ID(CHIP_ID), .REV_ID(REV_ID)) dut (
    .clk(clk), .rst(rst), .strap_alt(strap_alt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_en(dev_en), .dev_base(dev_base)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_lock;        // 0 locked, 1 one key seen, 2 open
  int m_idx;
  int m_ldn;
  int m_en   [NDEV];
  int m_base [NDEV];
  int m_rdata;

  task automatic model_reset();
    m_lock = 0; m_idx = 0; m_ldn = 0; m_rdata = 0;
    for (int i = 0; i < NDEV; i++) begin m_en[i] = 0; m_base[i] = 0; end
  endtask

  function automatic int model_reg();
    case (m_idx)
      'h07: return m_ldn;
      'h20: return int'(CHIP_ID);
      'h27: return int'(REV_ID);
      'h30: return m_en[m_ldn];
      'h60: return (m_base[m_ldn] >> 8) & 'hFF;
      'h61: return m_base[m_ldn] & 'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [NDEV-1:0]    exp_en;
    logic [NDEV*16-1:0] exp_base;
    for (int i = 0; i < NDEV; i++) begin
      exp_en[i] = m_en[i][0];
      exp_base[16*i +: 16] = m_base[i][15:0];
    end
    check({tag, " R12 rdata"}, int'(bus_rdata), m_rdata);
    checks++;
    if (dev_en !== exp_en) begin
      errors++;
      $display("FAIL R8 dev_en actual=0x%0h expected=0x%0h", dev_en, exp_en);
    end
    checks++;
    if (dev_base !== exp_base) begin
      errors++;
      $display("FAIL R9 dev_base actual=0x%0h expected=0x%0h", dev_base, exp_base);
    end
  endtask

  // kind: 0 idle, 1 write, 2 read
  task automatic op(input int kind, input int a, input int d, input string tag);
    int pidx;
    int nrd;
    @(negedge clk);
    bus_addr  = a[15:0];
    bus_wdata = d[7:0];
    bus_wr    = (kind == 1);
    bus_rd    = (kind == 2);
    pidx = strap_alt ? 'h4E : 'h2E;
    nrd  = 0;
    if (kind == 2 && a == pidx)     nrd = (m_lock == 2) ? m_idx : 'hFF;
    if (kind == 2 && a == pidx + 1) nrd = (m_lock == 2) ? model_reg() : 'hFF;
    if (kind == 1 && a == pidx) begin
      if (m_lock != 2) m_lock = (d == 'h87) ? m_lock + 1 : 0;
      else if (d == 'hAA) m_lock = 0;
      else m_idx = d;
    end
    if (kind == 1 && a == pidx + 1 && m_lock == 2) begin
      case (m_idx)
        'h07: if (d < NDEV) m_ldn = d;
        'h30: m_en[m_ldn] = d & 1;
        'h60: m_base[m_ldn] = (m_base[m_ldn] & 'hFF) | (d << 8);
        'h61: m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | d;
        default: ;
      endcase
    end
    m_rdata = nrd;
    @(posedge clk);
    #1;
    compare_all(tag);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  function automatic int ip(); return strap_alt ? 'h4E : 'h2E; endfunction

  task automatic iw(input int d, input string t); op(1, ip(), d, t); endtask
  task automatic dw(input int d, input string t); op(1, ip() + 1, d, t); endtask
  task automatic ir(input string t);              op(2, ip(), 0, t); endtask
  task automatic dr(input string t);              op(2, ip() + 1, 0, t); endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    model_reset();
    @(posedge clk); #1;
    compare_all("R11 reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    compare_all("R11 after reset");
  endtask

  task automatic enter(input string t);
    iw('h87, t); iw('h87, t);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // locked behaviour
    dr("R4 locked data read");
    ir("R4 locked index read");
    dw('h05, "R4 locked data write");
    // wrong pair while strap selects the low pair
    op(1, 'h4E, 'h87, "R1 wrong pair key");
    op(1, 'h4E, 'h87, "R1 wrong pair key");
    dr("R1 still locked");
    op(2, 'h1234, 0, "R1 foreign read");
    // interrupted key
    iw('h87, "R2 key1"); iw('h55, "R2 break"); iw('h87, "R2 key again");
    dr("R2 still locked");
    // data access between keys does not disturb
    iw('h87, "R2 key1");
    dr("R2 data between keys");
    iw('h87, "R2 key2");
    ir("R5 index read after unlock");
    iw('h20, "R5 set index"); ir("R5 index readback");
    dr("R7 chip id"); dw('h11, "R7 write id"); dr("R7 chip id kept");
    iw('h27, "R7 rev index"); dr("R7 rev id");
    // device select
    iw('h07, "R6 ldn index"); dw('h03, "R6 select 3"); dr("R6 read 3");
    dw('h09, "R6 select 9 ignored"); dr("R6 still 3");
    dw('h08, "R6 select 8 ignored"); dr("R6 still 3 b");
    // enable and base of device 3
    iw('h30, "R8 en index"); dw('hFE, "R8 bit0 clear"); dr("R8 read 0");
    dw('hFF, "R8 enable"); dr("R8 read 1");
    iw('h60, "R9 hi"); dw('h12, "R9 hi write"); dr("R9 hi read");
    iw('h61, "R9 lo"); dw('h34, "R9 lo write"); dr("R9 lo read");
    // device 7, banked copy
    iw('h07, "R6 ldn index"); dw('h07, "R6 select 7");
    iw('h30, "R8 en7 index"); dr("R8 dev7 starts off"); dw('h01, "R8 dev7 on");
    iw('h60, "R9 dev7 hi"); dw('hBE, "R9 dev7 hi w");
    iw('h61, "R9 dev7 lo"); dw('hEF, "R9 dev7 lo w"); dr("R9 dev7 lo r");
    // unimplemented registers
    iw('h45, "R10 idx"); dw('h77, "R10 write"); dr("R10 read 0");
    iw('hFF, "R10 idx ff"); dr("R10 read ff reg");
    // exit
    iw('h30, "R3 idx"); iw('hAA, "R3 exit");
    dw('h00, "R4 write after exit"); dr("R4 read after exit"); ir("R4 idx after exit");
    enter("R3 reenter"); ir("R3 index kept"); dr("R8 dev7 still on");
    op(0, 0, 0, "R12 idle");
    // strap to the high pair
    iw('hAA, "R3 exit2");
    strap_alt = 1'b1;
    op(1, 'h2E, 'h87, "R1 low pair ignored"); op(1, 'h2E, 'h87, "R1 low pair ignored");
    dr("R1 high pair locked");
    enter("R1 high pair enter"); iw('h20, "R1 idx"); dr("R1 high pair id");
    op(2, 'h2F, 0, "R1 low data read ignored");
    iw('h07, "R6 idx"); dw('h00, "R6 sel 0");
    iw('h61, "R9 dev0 lo"); dw('h5A, "R9 dev0 lo w");
    // reset mid run
    do_reset();
    dr("R11 locked after reset");
    enter("R11 reenter"); ir("R11 index zero"); iw('h07, "R11 ldn"); dr("R11 ldn zero");
    op(0, 0, 0, "R12 idle end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule